// File: doc/BRIEF.md
# Ping-Pong Sample Bank Splitter

This block takes one 9-bit converted word per sample clock and spreads the words over two output banks. Bit 8 of the word is an overflow flag and bits 7:0 are the sample value. Words go to bank A and bank B in turn, so each bank refreshes at half the sample rate. Each bank keeps its word for two sample periods while the stream runs, which gives a slower receiver time to capture it.

Each bank has a ready strobe and its complement. The strobe changes level every time its bank loads a new word. A receiver can therefore capture on either edge of the strobe, or on either edge of its complement. When a cycle arrives with the valid flag low, nothing changes: neither bank loads and the steering does not move on.

Steering is a two-state machine. In state `STEER_A` the next valid word goes to bank A. In state `STEER_B` it goes to bank B. On every valid cycle the machine takes the transition `GO_B` (STEER_A to STEER_B) or `GO_A` (STEER_B to STEER_A). On a cycle without valid it takes `STAY`. Reset puts the machine in `STEER_A`.

Top module: `pingpong_demux`

## Requirements
- R1: While reset is held, and right after it is released, both bank words are zero, both ready strobes are low and both complement strobes are high. The steering state is STEER_A.
- R2: The first valid word after reset is loaded into bank A. After that, valid words go to bank B and bank A in strict turn.
- R3: A word accepted on a rising clock edge shows on its bank's word output after that same edge.
- R4: A bank word keeps its value until the next load of that bank. In an unbroken stream this is two sample periods.
- R5: A bank's ready strobe inverts on every edge that loads that bank, and on no other edge.
- R6: Each complement strobe is the logical inverse of its bank's ready strobe in every cycle.
- R7: A cycle with valid low changes neither bank word nor either strobe. It does not advance the steering, so the next valid word goes to the bank that was due.
- R8: The overflow flag in bit 8 and the sample value in bits 7:0 reach the bank output together and unchanged.
- R9: No clock edge loads both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | The word on smp_word is valid this cycle |
| smp_word | input | 9 | Bit 8 is the overflow flag, bits 7:0 are the sample value |
| bank_a_word | output | 9 | Bank A word |
| bank_a_rdy | output | 1 | Bank A ready strobe, inverts on each bank A load |
| bank_a_nrdy | output | 1 | Complement of bank_a_rdy |
| bank_b_word | output | 9 | Bank B word |
| bank_b_rdy | output | 1 | Bank B ready strobe, inverts on each bank B load |
| bank_b_nrdy | output | 1 | Complement of bank_b_rdy |

## Verification
If the steering state is wrong, the next valid word lands in the wrong bank, and the wrong bank's strobe inverts. This shows at the ports one cycle after that word is accepted. A steering state that advances on an idle cycle is exposed by the first valid word after the gap. A bank register that loads at the wrong time either breaks the hold of its word or leaves its strobe out of step with its data. Either fault shows in the cycle after the bad edge. A complement strobe that drifts from its partner is caught in the same cycle it drifts.

// File: rtl/demux_pkg.sv
package demux_pkg;
    parameter int SAMPLE_W = 8;
    localparam int WORD_W  = SAMPLE_W + 1;
    localparam int BANKS   = 2;
    localparam int OVF_BIT = SAMPLE_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        STEER_A = 1'b0,
        STEER_B = 1'b1
    } steer_t;
endpackage

// File: rtl/bank_steer.sv
module bank_steer
    import demux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    output logic [BANKS-1:0] load
);
    steer_t state_q;
    steer_t state_d;

    // Next-state logic: GO_B / GO_A on valid, STAY otherwise.
    always_comb begin
        state_d = state_q;
        if (valid) begin
            unique case (state_q)
                STEER_A: state_d = STEER_B;
                STEER_B: state_d = STEER_A;
                default: state_d = STEER_A;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STEER_A;
        else        state_q <= state_d;
    end

    // Output process: the bank load enables.
    always_comb begin
        load = '0;
        if (valid) begin
            unique case (state_q)
                STEER_A: load[0] = 1'b1;
                STEER_B: load[1] = 1'b1;
                default: load    = '0;
            endcase
        end
    end

    assert_steer_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (state_q != $past(state_q)));

    assert_steer_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(state_q));
endmodule

// File: rtl/bank_reg.sv
module bank_reg
    import demux_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  word_t din,
    output word_t q,
    output logic  rdy,
    output logic  nrdy
);
    word_t q_r;
    logic  rdy_r;
    logic  nrdy_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= '0;
            rdy_r  <= 1'b0;
            nrdy_r <= 1'b1;
        end else if (load) begin
            q_r    <= din;
            rdy_r  <= ~rdy_r;
            nrdy_r <= ~nrdy_r;
        end
    end

    assign q    = q_r;
    assign rdy  = rdy_r;
    assign nrdy = nrdy_r;

    assert_load_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q_r == $past(din)));

    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(q_r) && $stable(rdy_r)));

    assert_strobe_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rdy_r != $past(rdy_r)));

    assert_strobe_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nrdy_r == ~rdy_r);
endmodule

// File: rtl/pingpong_demux.sv
module pingpong_demux
    import demux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_word,
    output logic [WORD_W-1:0] bank_a_word,
    output logic              bank_a_rdy,
    output logic              bank_a_nrdy,
    output logic [WORD_W-1:0] bank_b_word,
    output logic              bank_b_rdy,
    output logic              bank_b_nrdy
);
    logic [BANKS-1:0] load;
    word_t            bank_q [BANKS];
    logic [BANKS-1:0] rdy;
    logic [BANKS-1:0] nrdy;

    bank_steer u_steer (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (smp_valid),
        .load  (load)
    );

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        bank_reg u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load[g]),
            .din   (smp_word),
            .q     (bank_q[g]),
            .rdy   (rdy[g]),
            .nrdy  (nrdy[g])
        );
    end

    assign bank_a_word = bank_q[0];
    assign bank_a_rdy  = rdy[0];
    assign bank_a_nrdy = nrdy[0];
    assign bank_b_word = bank_q[1];
    assign bank_b_rdy  = rdy[1];
    assign bank_b_nrdy = nrdy[1];

    assert_single_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load));

    assert_valid_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ($countones(load) == 1));

    assert_ovf_carried_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load[0] |=> (bank_a_word[OVF_BIT] == $past(smp_word[OVF_BIT])));
endmodule

// File: tb/sim_pingpong_demux.sv
module sim_pingpong_demux;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [8:0] smp_word = '0;
    logic [8:0] bank_a_word, bank_b_word;
    logic       bank_a_rdy, bank_a_nrdy, bank_b_rdy, bank_b_nrdy;

    int n_cmp = 0;
    int n_bad = 0;
    bit running = 0;
    bit done = 0;

    // Expected items: bit 9 = bank (0 = A, 1 = B), bits 8:0 = word.
    logic [9:0] exp_q [$];
    logic       tb_sel = 1'b0;

    always #10 clk = ~clk;

    pingpong_demux u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_word(smp_word),
        .bank_a_word(bank_a_word), .bank_a_rdy(bank_a_rdy), .bank_a_nrdy(bank_a_nrdy),
        .bank_b_word(bank_b_word), .bank_b_rdy(bank_b_rdy), .bank_b_nrdy(bank_b_nrdy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input bit v, input logic [8:0] w);
        @(negedge clk);
        smp_valid = v;
        smp_word  = v ? w : 9'h0AA;
        if (v) begin
            exp_q.push_back({tb_sel, w});
            tb_sel = ~tb_sel;
        end
    endtask

    // Monitor / scoreboard
    logic       prev_a = 1'b0, prev_b = 1'b0;
    logic [8:0] hold_a = '0, hold_b = '0;
    always @(negedge clk) begin
        if (running) begin
            logic [9:0] item;
            check(bank_a_nrdy == ~bank_a_rdy, "R6 bank A pair", bank_a_nrdy, ~bank_a_rdy);
            check(bank_b_nrdy == ~bank_b_rdy, "R6 bank B pair", bank_b_nrdy, ~bank_b_rdy);
            check(!((bank_a_rdy != prev_a) && (bank_b_rdy != prev_b)), "R9 both banks moved",
                  {bank_a_rdy, bank_b_rdy}, {prev_a, prev_b});
            if (bank_a_rdy != prev_a) begin
                item = (exp_q.size() > 0) ? exp_q.pop_front() : 10'h3FF;
                check(item[9] == 1'b0, "R2 word steered to bank A", 0, item[9]);
                check(bank_a_word == item[8:0], "R3/R5/R8 bank A word", bank_a_word, item[8:0]);
                hold_a = bank_a_word;
            end else begin
                check(bank_a_word == hold_a, "R4/R7 bank A hold", bank_a_word, hold_a);
            end
            if (bank_b_rdy != prev_b) begin
                item = (exp_q.size() > 0) ? exp_q.pop_front() : 10'h3FF;
                check(item[9] == 1'b1, "R2 word steered to bank B", 1, item[9]);
                check(bank_b_word == item[8:0], "R3/R5/R8 bank B word", bank_b_word, item[8:0]);
                hold_b = bank_b_word;
            end else begin
                check(bank_b_word == hold_b, "R4/R7 bank B hold", bank_b_word, hold_b);
            end
            prev_a = bank_a_rdy;
            prev_b = bank_b_rdy;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(bank_a_word == 0 && bank_b_word == 0, "R1 words cleared", {bank_a_word, bank_b_word}, 0);
        check(!bank_a_rdy && bank_a_nrdy, "R1 bank A strobes", {bank_a_rdy, bank_a_nrdy}, 2'b01);
        check(!bank_b_rdy && bank_b_nrdy, "R1 bank B strobes", {bank_b_rdy, bank_b_nrdy}, 2'b01);
        rst_n = 1'b1;
        running = 1;
        // R2 first word to A, then alternate; R8 overflow and value patterns
        send(1, 9'h1FF); send(1, 9'h100); send(1, 9'h000); send(1, 9'h0FF);
        send(1, 9'h155); send(1, 9'h0AA);
        // R7 idle gaps of odd and even length
        send(0, 0); send(1, 9'h012); send(0, 0); send(0, 0); send(0, 0);
        send(1, 9'h134); send(1, 9'h056); send(0, 0); send(0, 0); send(1, 9'h178);
        // Longer stream of computed words (R4 steady hold)
        for (int i = 0; i < 40; i++) send(1, 9'((i * 37 + 11) % 512));
        send(0, 0); send(0, 0); send(0, 0);
        check(exp_q.size() == 0, "R2/R5 every word delivered", exp_q.size(), 0);
        running = 0;
        done = 1;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
        end
        done = 1;
    end

    initial begin
        wait (done);
        #1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule